// File: doc/BRIEF.md
# Receive Jitter Attenuator Elastic Buffer

This block absorbs phase wander on a bit-serial receive line of T1/E1 class. Everything runs on one fast system clock. Each recovered line bit arrives with a one-cycle write strobe and goes into a 32-bit elastic buffer. Bits leave the buffer on a read strobe that an internal rate loop produces. The loop counts a programmable number of system clocks per output bit, `divisor + 1`. At each output bit it lengthens or shortens the next output period by one clock. Which way it moves depends on the sign of an accumulator that sums written bits minus read bits.

Two options manage the buffer's read pointer. Self-centering moves the read pointer back to a half-full buffer once the fill level comes within 4 bits of either end. Enabling this option also causes one immediate re-centering. Limit mode instead forces the loop's largest rate correction when the fill level comes within 1 bit of either end. An underrun or an overwrite each set a sticky flag. Each flag can raise a shared interrupt line.

A four-address register port holds the divisor, the configuration, the sticky flags and a read-only fill level.

Top module: `jat_top`

## Requirements
- R1: After reset, the registers read as follows: divisor (address 0) 0x2F, configuration (address 1) 0x01, status (address 2) 0x00, fill (address 3) 0. The `irq` output is 0.
- R2: With self-centering off, bits leave on `out_bit` in the order they were written. A read strobe while the buffer is empty does not advance the read pointer.
- R3: A read strobe while the fill level is 0 sets status bit 0 (underrun). The bit stays set until a register write to address 2 has bit 0 = 1. A new event in the same cycle wins over the clear.
- R4: A write strobe while the fill level is 32 sets status bit 1 (overwrite). The new bit is stored, the oldest bit is dropped, and the fill level stays 32. The bit is cleared by writing 1 to status bit 1.
- R5: `irq` is 1 exactly when (status bit 0 AND configuration bit 3) or (status bit 1 AND configuration bit 2).
- R6: A register write to address 0 restarts the rate loop. The next read strobe shows `divisor` cycles after the first cycle that follows the write.
- R7: The period that follows each read strobe is chosen from the accumulator value before that cycle's update. It is `divisor + 1` cycles when the accumulator is zero, `divisor` cycles when it is positive (never less than 1), and `divisor + 2` cycles when it is negative. The accumulator adds 1 per write strobe and subtracts 1 per read strobe, and it saturates.
- R8: With configuration bit 0 (limit) set, a fill level of at most 1 at a read strobe forces the next period to `divisor + 2`. A fill level of at least 31 forces it to `divisor`. This overrides the accumulator.
- R9: With configuration bit 4 (self-center) set, a fill level of at most 4 or at least 28 makes the fill level exactly 16 in the next cycle. With bit 4 clear, the buffer never re-centers.
- R10: A register write that changes configuration bit 4 from 0 to 1 re-centers the buffer to a fill level of 16 at once, whatever the current fill level.
- R11: Configuration bits 7:5 and 1 read as 0 and ignore writes. Status bits 7:2 read as 0.
- R12: Address 3 reads the current fill level, 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_bit_vld | input | 1 | Write strobe, one cycle per recovered line bit |
| line_bit | input | 1 | Recovered line bit |
| out_bit_vld | output | 1 | Smoothed read strobe |
| out_bit | output | 1 | Bit at the read pointer, valid with `out_bit_vld` |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 divisor, 1 configuration, 2 status, 3 fill) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Shared interrupt, active high |

## Verification
Assertions check on every cycle that the fill level stays within the buffer depth. They check that an underrun or overwrite event leaves its sticky flag set in the next cycle and that an overwrite keeps the buffer full. They check that every re-centering lands on exactly half depth and that a divisor write suppresses the read strobe in the following cycle. Only the bench scenarios can show the strobe spacing after a loop restart, and how that spacing bends with the accumulator sign and with limit mode. The same goes for bit order under random write densities, the clearing of sticky flags and the masking of the interrupt.

// File: rtl/jat_pkg.sv
// Shared register map and field positions for the jitter attenuator.
package jat_pkg;
    typedef enum logic [1:0] {
        RA_DIV  = 2'd0,
        RA_CFG  = 2'd1,
        RA_STAT = 2'd2,
        RA_FILL = 2'd3
    } reg_addr_e;

    localparam int CFG_LIMIT_BIT  = 0;
    localparam int CFG_OVIE_BIT   = 2;
    localparam int CFG_URIE_BIT   = 3;
    localparam int CFG_CENTER_BIT = 4;

    localparam int ST_UR_BIT = 0;
    localparam int ST_OV_BIT = 1;

    typedef struct packed {
        logic center;
        logic ur_ie;
        logic ov_ie;
        logic limit;
    } cfg_t;
endpackage

// File: rtl/jat_regs.sv
// Register block: divisor, configuration, sticky status (write 1 to clear), fill readback.
// Assumes single-cycle writes; read data is combinational from reg_addr.
module jat_regs
    import jat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FILL_W = 6,
    parameter logic [DATA_W-1:0] DIV_RST = 8'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ur_evt,
    input  logic              ov_evt,
    input  logic [FILL_W-1:0] fill,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] div_q,
    output logic              div_wr,
    output cfg_t              cfg_q,
    output logic              center_kick,
    output logic              ur_sticky,
    output logic              ov_sticky,
    output logic              irq
);
    logic cfg_wr;
    logic stat_wr;

    // Decode write strobes per register.
    always_comb begin
        div_wr  = reg_we && (reg_addr == RA_DIV);
        cfg_wr  = reg_we && (reg_addr == RA_CFG);
        stat_wr = reg_we && (reg_addr == RA_STAT);
    end

    // One-shot re-center request on a 0-to-1 write of the center enable.
    assign center_kick = cfg_wr && reg_wdata[CFG_CENTER_BIT] && !cfg_q.center;

    // Divisor and configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RST;
            cfg_q <= '{center: 1'b0, ur_ie: 1'b0, ov_ie: 1'b0, limit: 1'b1};
        end else begin
            if (div_wr) div_q <= reg_wdata;
            if (cfg_wr) begin
                cfg_q.center <= reg_wdata[CFG_CENTER_BIT];
                cfg_q.ur_ie  <= reg_wdata[CFG_URIE_BIT];
                cfg_q.ov_ie  <= reg_wdata[CFG_OVIE_BIT];
                cfg_q.limit  <= reg_wdata[CFG_LIMIT_BIT];
            end
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ur_sticky <= 1'b0;
            ov_sticky <= 1'b0;
        end else begin
            ur_sticky <= ur_evt || (ur_sticky && !(stat_wr && reg_wdata[ST_UR_BIT]));
            ov_sticky <= ov_evt || (ov_sticky && !(stat_wr && reg_wdata[ST_OV_BIT]));
        end
    end

    // Shared interrupt from masked flags.
    assign irq = (ur_sticky && cfg_q.ur_ie) || (ov_sticky && cfg_q.ov_ie);

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_DIV:  reg_rdata = div_q;
            RA_CFG: begin
                reg_rdata[CFG_CENTER_BIT] = cfg_q.center;
                reg_rdata[CFG_URIE_BIT]   = cfg_q.ur_ie;
                reg_rdata[CFG_OVIE_BIT]   = cfg_q.ov_ie;
                reg_rdata[CFG_LIMIT_BIT]  = cfg_q.limit;
            end
            RA_STAT: begin
                reg_rdata[ST_UR_BIT] = ur_sticky;
                reg_rdata[ST_OV_BIT] = ov_sticky;
            end
            default: reg_rdata = DATA_W'(fill);
        endcase
    end
endmodule

// File: rtl/jat_fifo.sv
// Elastic bit buffer with read-pointer management.
// Assumes DEPTH is a power of two; pointers carry one extra wrap bit so fill spans 0..DEPTH.
// Overwrite drops the oldest bit; underrun holds the read pointer.
// Re-centering places the read pointer DEPTH/2 behind the next write pointer.
module jat_fifo #(
    parameter int DEPTH         = 32,
    parameter int CENTER_MARGIN = 4,
    localparam int PTR_W        = $clog2(DEPTH),
    localparam int FILL_W       = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic              wr_bit,
    input  logic              rd_vld,
    input  logic              center_en,
    input  logic              center_kick,
    output logic              rd_bit,
    output logic [FILL_W-1:0] fill,
    output logic              ur_evt,
    output logic              ov_evt,
    output logic              recenter_go
);
    localparam logic [FILL_W-1:0] HALF    = FILL_W'(DEPTH / 2);
    localparam logic [FILL_W-1:0] FULL    = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] CTR_LO  = FILL_W'(CENTER_MARGIN);
    localparam logic [FILL_W-1:0] CTR_HI  = FILL_W'(DEPTH - CENTER_MARGIN);

    logic [DEPTH-1:0]  mem_q;
    logic [FILL_W-1:0] wp_q, rp_q, wp_nx;
    logic              is_empty, is_full, near_edge, rp_adv;

    // Fill level and boundary events.
    always_comb begin
        fill      = wp_q - rp_q;
        is_empty  = (fill == '0);
        is_full   = (fill == FULL);
        ur_evt    = rd_vld && is_empty;
        ov_evt    = wr_vld && is_full;
        near_edge = center_en && ((fill <= CTR_LO) || (fill >= CTR_HI));
        recenter_go = near_edge || center_kick;
        rp_adv    = (rd_vld && !is_empty) || ov_evt;
        wp_nx     = wp_q + FILL_W'(wr_vld);
    end

    assign rd_bit = mem_q[rp_q[PTR_W-1:0]];

    // Bit storage.
    always_ff @(posedge clk) begin
        if (wr_vld) mem_q[wp_q[PTR_W-1:0]] <= wr_bit;
    end

    // Pointer update: re-center overrides the normal read advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            wp_q <= wp_nx;
            if (recenter_go)  rp_q <= wp_nx - HALF;
            else if (rp_adv)  rp_q <= rp_q + 1'b1;
        end
    end
endmodule

// File: rtl/jat_dpll.sv
// Digital rate loop producing the smoothed read strobe.
// A period counter fires when it reaches the target; the next target is the divisor,
// bent by one clock from the accumulator sign or, in limit mode, from the fill level.
// A divisor write restarts the counter and clears the accumulator.
module jat_dpll #(
    parameter int DIV_W        = 8,
    parameter int FILL_W       = 6,
    parameter int DEPTH        = 32,
    parameter int LIMIT_MARGIN = 1,
    parameter int ACC_W        = 10,
    parameter logic [DIV_W-1:0] DIV_RST = 8'h2F,
    localparam int TGT_W       = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_q,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_new,
    input  logic              limit_en,
    input  logic              wr_vld,
    input  logic [FILL_W-1:0] fill,
    output logic              rd_vld
);
    localparam logic [FILL_W-1:0] LIM_LO = FILL_W'(LIMIT_MARGIN);
    localparam logic [FILL_W-1:0] LIM_HI = FILL_W'(DEPTH - LIMIT_MARGIN);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = -ACC_MAX;

    logic [TGT_W-1:0]        cnt_q, tgt_q, nom, slow, fast, tgt_nx;
    logic signed [ACC_W-1:0] acc_q, acc_nx;
    logic                    acc_pos, acc_neg;

    assign rd_vld = (cnt_q == tgt_q);

    // Choose the next period target.
    always_comb begin
        nom     = TGT_W'(div_q);
        slow    = nom + 1'b1;
        fast    = (nom == '0) ? '0 : nom - 1'b1;
        acc_neg = acc_q[ACC_W-1];
        acc_pos = !acc_neg && (acc_q != '0);
        if (limit_en && (fill <= LIM_LO))      tgt_nx = slow;
        else if (limit_en && (fill >= LIM_HI)) tgt_nx = fast;
        else if (acc_pos)                      tgt_nx = fast;
        else if (acc_neg)                      tgt_nx = slow;
        else                                   tgt_nx = nom;
    end

    // Saturating phase accumulator: writes minus reads.
    always_comb begin
        case ({wr_vld, rd_vld})
            2'b10:   acc_nx = (acc_q == ACC_MAX) ? acc_q : acc_q + 1'b1;
            2'b01:   acc_nx = (acc_q == ACC_MIN) ? acc_q : acc_q - 1'b1;
            default: acc_nx = acc_q;
        endcase
    end

    // Period counter, target and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= TGT_W'(DIV_RST);
            acc_q <= '0;
        end else if (div_wr) begin
            cnt_q <= '0;
            tgt_q <= TGT_W'(div_new);
            acc_q <= '0;
        end else begin
            acc_q <= acc_nx;
            if (rd_vld) begin
                cnt_q <= '0;
                tgt_q <= tgt_nx;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/jat_top.sv
// Receive jitter attenuator: elastic bit buffer, rate loop and register block.
// Assumes one write strobe per recovered bit on the system clock domain.
module jat_top
    import jat_pkg::*;
#(
    parameter int DEPTH         = 32,
    parameter int DATA_W        = 8,
    parameter int ACC_W         = 10,
    parameter int CENTER_MARGIN = 4,
    parameter int LIMIT_MARGIN  = 1,
    parameter logic [DATA_W-1:0] DIV_RST = 8'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_bit_vld,
    input  logic              line_bit,
    output logic              out_bit_vld,
    output logic              out_bit,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int FILL_W = $clog2(DEPTH) + 1;

    logic [FILL_W-1:0] fill;
    logic [DATA_W-1:0] div_q;
    cfg_t              cfg_q;
    logic              div_wr, center_kick, ur_evt, ov_evt, recenter_go;
    logic              ur_sticky, ov_sticky;

    jat_regs #(.DATA_W(DATA_W), .FILL_W(FILL_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ur_evt(ur_evt), .ov_evt(ov_evt), .fill(fill),
        .reg_rdata(reg_rdata), .div_q(div_q), .div_wr(div_wr), .cfg_q(cfg_q),
        .center_kick(center_kick), .ur_sticky(ur_sticky), .ov_sticky(ov_sticky),
        .irq(irq)
    );

    jat_fifo #(.DEPTH(DEPTH), .CENTER_MARGIN(CENTER_MARGIN)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_vld(line_bit_vld), .wr_bit(line_bit),
        .rd_vld(out_bit_vld), .center_en(cfg_q.center), .center_kick(center_kick),
        .rd_bit(out_bit), .fill(fill), .ur_evt(ur_evt), .ov_evt(ov_evt),
        .recenter_go(recenter_go)
    );

    jat_dpll #(.DIV_W(DATA_W), .FILL_W(FILL_W), .DEPTH(DEPTH),
               .LIMIT_MARGIN(LIMIT_MARGIN), .ACC_W(ACC_W), .DIV_RST(DIV_RST)) u_dpll (
        .clk(clk), .rst_n(rst_n), .div_q(div_q), .div_wr(div_wr),
        .div_new(reg_wdata), .limit_en(cfg_q.limit), .wr_vld(line_bit_vld),
        .fill(fill), .rd_vld(out_bit_vld)
    );
endmodule

// File: rtl/jat_chk.sv
// Property checker for jat_top, attached by bind.
module jat_chk #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int FILL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_vld,
    input logic              rd_vld,
    input logic [FILL_W-1:0] fill,
    input logic              recenter_go,
    input logic              ur_sticky,
    input logic              ov_sticky,
    input logic              div_wr,
    input logic [DATA_W-1:0] div_new
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] HALF = FILL_W'(DEPTH / 2);

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);                                              // R12
    AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && fill == '0) |=> ur_sticky);                      // R3
    AST_OV_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && fill == FULL) |=> (ov_sticky && fill == FULL));  // R4
    AST_CENTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        recenter_go |=> (fill == HALF));                            // R9
    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && div_new != '0) |=> !rd_vld);                     // R6
endmodule

bind jat_top jat_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_vld(line_bit_vld), .rd_vld(out_bit_vld),
    .fill(fill), .recenter_go(recenter_go), .ur_sticky(ur_sticky),
    .ov_sticky(ov_sticky), .div_wr(div_wr), .div_new(reg_wdata)
);

// File: tb/tb_jat_top.sv
module tb_jat_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit_vld = 1'b0, line_bit = 1'b0;
    logic       out_bit_vld, out_bit;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    jat_top dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int   n_chk = 0, n_err = 0;
    bit   q[$];
    bit   exp_ur, exp_ov, model_ok;
    logic last_irq, last_rv;
    logic [7:0] rdat;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected sticky flag after one cycle: event sets, write-1 clears.
    function automatic bit sticky_next(bit cur, bit evt, bit clr);
        return evt | (cur & ~clr);
    endfunction

    // One clock cycle: drive at negedge, sample outputs, advance the bench model.
    task automatic cyc(input logic wv, input logic wb, input logic we,
                       input logic [1:0] a, input logic [7:0] d);
        bit ur_e, ov_e;
        @(negedge clk);
        line_bit_vld = wv; line_bit = wb;
        reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        last_rv  = out_bit_vld;
        last_irq = irq;
        rdat     = reg_rdata;
        if (model_ok) begin
            ur_e = last_rv && (q.size() == 0);
            ov_e = wv && (q.size() == 32);
            if (last_rv && q.size() > 0) begin
                check("R2", int'(out_bit), int'(q[0]));
                void'(q.pop_front());
            end
            if (wv) begin
                if (q.size() == 32) void'(q.pop_front());
                q.push_back(wb);
            end
            exp_ur = sticky_next(exp_ur, ur_e, we && a == 2'd2 && d[0]);
            exp_ov = sticky_next(exp_ov, ov_e, we && a == 2'd2 && d[1]);
        end
    endtask

    task automatic idle();                          cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'd0); endtask
    task automatic wbit(input logic b);             cyc(1'b1, b, 1'b0, 2'd0, 8'd0);    endtask
    task automatic rwr(input logic [1:0] a, input logic [7:0] d); cyc(1'b0, 1'b0, 1'b1, a, d); endtask
    task automatic rrd(input logic [1:0] a);        cyc(1'b0, 1'b0, 1'b0, a, 8'd0);    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; line_bit_vld = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q.delete(); exp_ur = 0; exp_ov = 0; model_ok = 1;
    endtask

    // Measure strobe spacing after a divisor write; wv drives a write every cycle.
    task automatic measure(input logic wv, output int first, output int g1, output int g2);
        int s[3];
        int n = 0;
        for (int i = 0; i < 3000 && n < 3; i++) begin
            cyc(wv, i[0], 1'b0, 2'd0, 8'd0);
            if (last_rv) begin s[n] = i; n++; end
        end
        first = s[0]; g1 = s[1] - s[0]; g2 = s[2] - s[1];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int f, g1, g2;
        void'($urandom(32'd20240611));

        // R1: reset values
        do_reset();
        rrd(2'd0); check("R1 div", rdat, 8'h2F);
        rrd(2'd1); check("R1 cfg", rdat, 8'h01);
        rrd(2'd2); check("R1 stat", rdat, 8'h00);
        rrd(2'd3); check("R1 fill", rdat, 0);
        check("R1 irq", last_irq, 0);

        // R11: reserved bits
        model_ok = 0;
        rwr(2'd1, 8'hFF); rrd(2'd1); check("R11 cfg", rdat, 8'h1D);
        rwr(2'd2, 8'hFF); rrd(2'd2); check("R11 stat", rdat & 8'hFC, 0);

        // R6/R7: no writes, limit off
        do_reset(); rwr(2'd1, 8'h00); rwr(2'd0, 8'd7);
        measure(1'b0, f, g1, g2);
        check("R6 first strobe", f, 7);
        check("R7 zero acc period", g1, 8);
        check("R7 negative acc period", g2, 9);

        // R8: limit on near empty
        do_reset(); rwr(2'd0, 8'd7);
        measure(1'b0, f, g1, g2);
        check("R8 slow near empty", g1, 9);

        // R7: positive accumulator
        do_reset(); rwr(2'd1, 8'h00); rwr(2'd0, 8'd9);
        measure(1'b1, f, g1, g2);
        check("R7 positive acc period", g1, 9);

        // R8: limit on near full
        do_reset(); rwr(2'd0, 8'd63);
        measure(1'b1, f, g1, g2);
        check("R8 fast near full", g1, 63);

        // R3/R5: underrun, masking, clear
        do_reset(); rwr(2'd1, 8'h00); rwr(2'd0, 8'd3);
        repeat (10) idle();
        rrd(2'd2); check("R3 underrun set", rdat[0], 1);
        check("R5 masked irq", last_irq, 0);
        rwr(2'd1, 8'h08); idle(); check("R5 ur irq", last_irq, 1);
        rwr(2'd0, 8'd255); rwr(2'd2, 8'h01);
        rrd(2'd2); check("R3 underrun clear", rdat[0], 0);
        check("R5 irq after clear", last_irq, 0);

        // R4/R5: overwrite, then drain to confirm the oldest bit was dropped
        do_reset(); rwr(2'd0, 8'd255); rwr(2'd1, 8'h04);
        for (int i = 0; i < 33; i++) wbit(logic'((i % 3) == 0));
        rrd(2'd2); check("R4 overwrite set", rdat[1], 1);
        rrd(2'd3); check("R4 fill stays full", rdat, 32);
        check("R5 ov irq", last_irq, 1);
        rwr(2'd0, 8'd1);
        repeat (80) idle();
        rwr(2'd2, 8'h02); rrd(2'd2); check("R4 overwrite clear", rdat[1], 0);

        // R10/R9/R12: re-centering
        do_reset(); rwr(2'd1, 8'h00); rwr(2'd0, 8'd255);
        for (int i = 0; i < 10; i++) wbit(1'b1);
        rrd(2'd3); check("R12 fill level", rdat, 10);
        model_ok = 0;
        rwr(2'd1, 8'h10); rrd(2'd3); check("R10 kick centers", rdat, 16);
        for (int i = 0; i < 12; i++) wbit(1'b0);
        idle(); rrd(2'd3); check("R9 auto center", rdat, 16);
        do_reset(); rwr(2'd1, 8'h00); rwr(2'd0, 8'd255);
        for (int i = 0; i < 28; i++) wbit(1'b1);
        idle(); rrd(2'd3); check("R9 disabled holds", rdat, 28);

        // R2: random densities against the bench model
        do_reset(); rwr(2'd1, ($urandom % 2) ? 8'h01 : 8'h00); rwr(2'd0, 8'd3);
        for (int s = 0; s < 20; s++) begin
            int p = $urandom % 101;
            for (int i = 0; i < 200; i++)
                cyc(($urandom % 100) < p, logic'($urandom % 2), 1'b0, 2'd0, 8'd0);
        end
        rrd(2'd2);
        check("R3 random underrun flag", rdat[0], exp_ur);
        check("R4 random overwrite flag", rdat[1], exp_ov);
        rrd(2'd3); check("R12 random fill", rdat, q.size());

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule